// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the digital control of a 1024-element linear photodiode array. On every pixel-rate clock it presents one output group: a run of adjacent photodiodes whose length is set by a two-bit resolution select. It raises a valid flag for each clock of the frame. A readout begins when the start input is seen high at a rising edge. The frame then runs without further attention until its last group and stops there. A new frame can follow back to back if start is high again at that moment.

Around the group token the block makes the control lines for the analog side. A global pixel reset is decoded straight from the reset and shutter pins in frame mode. In dynamic reset mode a per-group reset strobe trails the readout by one cycle. An enable mask powers only the column amplifiers that the selected resolution needs. An output-driver enable drops in standby. Standby is requested by holding the reset and start pins high together. The analog summing, sample-and-hold and video amplifier are not part of the block. They only see its select and enable lines.

Top module: `lsr_seq`

## Requirements
- R1: Resolution code 0 (binary 00) gives 1024 groups per frame, 1 gives 512, 2 gives 256 and 3 gives 128; a frame lasts exactly that many valid clocks.
- R2: The group index counts output groups from 0 to count-1, never physical pixels, and stays below the group count while valid.
- R3: While a frame runs, exactly one group is valid per clock, and each index is one above the previous.
- R4: When start is sampled high at a rising edge while idle, valid goes high with index 0 and the first-group select high in the cycle after that edge.
- R5: If start is still high at the next rising edge, index 1 is presented while the first-group select stays high; it drops after start is sampled low.
- R6: While hold (reset pin) is high, the token is cleared: valid and the first-group select are low. After hold is released, no frame starts until start is seen high.
- R7: With hold and start high together (standby), the output-driver enable and every amplifier enable are low, combinationally.
- R8: Outside standby, exactly the lowest group-count amplifier enables (bits 0 to count-1 of the mask) are high, following the live resolution pins.
- R9: With reset mode 0, the global pixel reset equals hold AND shutter, without waiting for a clock edge; with reset mode 1 it stays low.
- R10: With reset mode 1, the group presented in one cycle is strobed for reset in the next cycle, with its index on the reset-index output; with reset mode 0 the strobe stays low.
- R11: After the last group, valid falls and the block idles; if start is high at the edge that ends the last group, index 0 follows with no gap.
- R12: The resolution is captured when a frame starts; changing the resolution pins during a frame does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start-readout request |
| hold_i | input | 1 | Reset pin: clears token; standby together with start |
| shutter_i | input | 1 | Shutter pin for frame-mode pixel reset |
| res_sel_i | input | 2 | Resolution code (0: 1024, 1: 512, 2: 256, 3: 128 groups) |
| dyn_mode_i | input | 1 | Reset mode: 0 frame, 1 dynamic per-group |
| grp_idx_o | output | 10 | Current output group index |
| grp_valid_o | output | 1 | One valid group this cycle |
| first_sel_o | output | 1 | First-group select line |
| grp_rst_o | output | 1 | Per-group reset strobe (dynamic mode) |
| grp_rst_idx_o | output | 10 | Index of the group being reset |
| pix_rst_o | output | 1 | Global pixel reset (frame mode) |
| amp_en_o | output | 1024 | Column amplifier enable mask |
| drv_en_o | output | 1 | Output-driver enable |

## Verification
The hardest state to reach from the ports is the overlap cycle, where the first-group select and the advancing token are both active. It appears only when start is kept high across exactly two rising edges. The bench holds start for one extra cycle and checks index 1 with the first select still high. A second hard case is the frame boundary. The bench raises start exactly when the last group is on the outputs and expects index 0 with no idle cycle. It also changes the resolution pins in mid-frame and checks that the frame length stays the same while the amplifier mask follows the new resolution.

// File: rtl/lsr_pkg.sv
// Package: shared resolution encoding and the group-count helper.
// Assumes the array size is a power of two no smaller than 8.
package lsr_pkg;

    typedef enum logic [1:0] {
        RES_FULL    = 2'd0,
        RES_HALF    = 2'd1,
        RES_QUARTER = 2'd2,
        RES_EIGHTH  = 2'd3
    } res_e;

    // Number of output groups for a given array size and resolution code.
    function automatic int unsigned grp_count(input int unsigned npix, input logic [1:0] res);
        return npix >> res;
    endfunction

endpackage

// File: rtl/lsr_token.sv
// Module: group token. Walks the output-group index once per clock over one
// frame and tracks the first-group select line.
// Assumes: hold_i clears the token synchronously; the resolution is captured
// at frame start.
module lsr_token #(
    parameter int NPIX = 1024,
    parameter int IDXW = $clog2(NPIX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_i,
    input  logic            start_i,
    input  logic [1:0]      res_i,
    output logic            valid_o,
    output logic [IDXW-1:0] idx_o,
    output logic            first_o
);
    localparam int CNTW = IDXW + 1;

    logic            valid_q;
    logic [IDXW-1:0] idx_q;
    logic            first_q;
    logic [1:0]      res_q;
    logic [CNTW-1:0] cnt_q;
    logic            last;

    // Group count of the running frame.
    assign cnt_q = CNTW'(lsr_pkg::grp_count(NPIX, res_q));
    // Final group of the running frame on the outputs.
    assign last  = valid_q && ({1'b0, idx_q} == cnt_q - 1'b1);

    // Token advance, frame start and hold clear.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
            first_q <= 1'b0;
            if (!rst_n) res_q <= 2'd0;
        end else begin
            first_q <= start_i;
            if (!valid_q || last) begin
                idx_q <= '0;
                if (start_i) begin
                    valid_q <= 1'b1;
                    res_q   <= res_i;
                end else begin
                    valid_q <= 1'b0;
                end
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
    assign idx_o   = idx_q;
    assign first_o = first_q;

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !last && !hold_i) |=> (valid_q && idx_q == $past(idx_q) + 1'b1));
    p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && start_i && !hold_i) |=> (valid_q && idx_q == '0 && first_q));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!valid_q && !first_q));
    p_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start_i && !hold_i) |=> !valid_q);
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ({1'b0, idx_q} < cnt_q));
endmodule

// File: rtl/lsr_amp_mask.sv
// Module: column amplifier enable mask. Enables the lowest group-count
// amplifiers and clears all of them in standby.
// Assumes: combinational from pins; clk and rst_n only time the checks.
module lsr_amp_mask #(
    parameter int NPIX = 1024
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      res_i,
    input  logic            stby_i,
    output logic [NPIX-1:0] amp_en_o
);
    localparam int CNTW = $clog2(NPIX) + 1;

    logic [CNTW-1:0] cnt;

    // Live group count from the resolution pins.
    assign cnt = CNTW'(lsr_pkg::grp_count(NPIX, res_i));

    for (genvar j = 0; j < NPIX; j++) begin : g_col
        // One enable per column amplifier.
        assign amp_en_o[j] = !stby_i && (CNTW'(j) < cnt);
    end

    p_mask_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stby_i |-> ($countones(amp_en_o) == int'(cnt) && amp_en_o[0]));
endmodule

// File: rtl/lsr_dyn_rst.sv
// Module: dynamic per-group reset. Strobes the group read last cycle.
// Assumes: hold_i clears the strobe; frame mode keeps it low.
module lsr_dyn_rst #(
    parameter int IDXW = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_i,
    input  logic            dyn_i,
    input  logic            valid_i,
    input  logic [IDXW-1:0] idx_i,
    output logic            grp_rst_o,
    output logic [IDXW-1:0] grp_rst_idx_o
);
    // One-cycle-late reset strobe and index.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            grp_rst_o     <= 1'b0;
            grp_rst_idx_o <= '0;
        end else begin
            grp_rst_o     <= dyn_i && valid_i;
            grp_rst_idx_o <= idx_i;
        end
    end

    p_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dyn_i && valid_i && !hold_i) |=> (grp_rst_o && grp_rst_idx_o == $past(idx_i)));
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dyn_i |=> !grp_rst_o);
endmodule

// File: rtl/lsr_seq.sv
// Module: linear sensor readout sequencer top. Joins the group token, the
// amplifier mask and the dynamic reset, and decodes standby and global reset.
// Assumes: pins are synchronous to clk except the pixel-reset path.
module lsr_seq #(
    parameter int NPIX = 1024,
    parameter int IDXW = $clog2(NPIX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            hold_i,
    input  logic            shutter_i,
    input  logic [1:0]      res_sel_i,
    input  logic            dyn_mode_i,
    output logic [IDXW-1:0] grp_idx_o,
    output logic            grp_valid_o,
    output logic            first_sel_o,
    output logic            grp_rst_o,
    output logic [IDXW-1:0] grp_rst_idx_o,
    output logic            pix_rst_o,
    output logic [NPIX-1:0] amp_en_o,
    output logic            drv_en_o
);
    logic stby;

    // Standby decode from the two pins held together.
    assign stby      = hold_i && start_i;
    // Output driver off in standby.
    assign drv_en_o  = !stby;
    // Frame-mode global pixel reset, clock-free.
    assign pix_rst_o = !dyn_mode_i && hold_i && shutter_i;

    lsr_token #(.NPIX(NPIX), .IDXW(IDXW)) i_token (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (hold_i),
        .start_i (start_i),
        .res_i   (res_sel_i),
        .valid_o (grp_valid_o),
        .idx_o   (grp_idx_o),
        .first_o (first_sel_o)
    );

    lsr_amp_mask #(.NPIX(NPIX)) i_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_i    (res_sel_i),
        .stby_i   (stby),
        .amp_en_o (amp_en_o)
    );

    lsr_dyn_rst #(.IDXW(IDXW)) i_dyn (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold_i        (hold_i),
        .dyn_i         (dyn_mode_i),
        .valid_i       (grp_valid_o),
        .idx_i         (grp_idx_o),
        .grp_rst_o     (grp_rst_o),
        .grp_rst_idx_o (grp_rst_idx_o)
    );

    p_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && start_i) |-> (!drv_en_o && amp_en_o == '0));
endmodule

// File: tb/test_lsr_seq.sv
module test_lsr_seq;
    localparam int NPIX = 1024;
    localparam int IDXW = 10;
    localparam int NVEC = 4;
    localparam logic [1:0] T_RES [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3};
    localparam int         T_LEN [NVEC] = '{1024, 512, 256, 128};
    localparam bit         T_DYN [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, hold = 1'b0, shut = 1'b0, dyn = 1'b0;
    logic [1:0] res = 2'd0;
    logic [IDXW-1:0] idx, rst_idx;
    logic valid, first, grp_rst, pix_rst, drv_en;
    logic [NPIX-1:0] amp_en;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    lsr_seq #(.NPIX(NPIX), .IDXW(IDXW)) i_lsr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .hold_i(hold),
        .shutter_i(shut), .res_sel_i(res), .dyn_mode_i(dyn),
        .grp_idx_o(idx), .grp_valid_o(valid), .first_sel_o(first),
        .grp_rst_o(grp_rst), .grp_rst_idx_o(rst_idx), .pix_rst_o(pix_rst),
        .amp_en_o(amp_en), .drv_en_o(drv_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one frame from a one-cycle start pulse; counts sequence errors.
    task automatic run_frame(input bit dm, output int len, output int err);
        len = 0; err = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (valid && len < 2000) begin
            if (int'(idx) != len) err++;
            if (dm && len > 0 && !(grp_rst && int'(rst_idx) == len - 1)) err++;
            if (!dm && grp_rst) err++;
            len++;
            @(negedge clk);
        end
        if (dm && !(grp_rst && int'(rst_idx) == len - 1)) err++;
    endtask

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int len, err;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk(!valid && !first && !grp_rst, "R6 reset idle", valid, 0);
        chk(drv_en, "R7 driver on after reset", drv_en, 1);
        chk($countones(amp_en) == 1024, "R8 full mask", $countones(amp_en), 1024);

        // Table walk: resolution, frame length, index order, dynamic strobe
        for (int v = 0; v < NVEC; v++) begin
            res = T_RES[v]; dyn = T_DYN[v];
            #1;
            chk($countones(amp_en) == T_LEN[v], "R8 mask count", $countones(amp_en), T_LEN[v]);
            run_frame(T_DYN[v], len, err);
            chk(len == T_LEN[v], "R1 frame length", len, T_LEN[v]);
            chk(err == 0, "R2 R3 R10 sequence", err, 0);
            @(negedge clk);
            chk(!valid, "R11 idle after frame", valid, 0);
        end
        dyn = 1'b0;

        // R4/R5: start held across two edges
        res = 2'd3;
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        chk(valid && idx == 0 && first, "R4 first group", int'(idx), 0);
        @(negedge clk); start = 1'b0;
        chk(valid && idx == 1 && first, "R5 overlap select", int'(first), 1);
        @(negedge clk);
        chk(valid && idx == 2 && !first, "R5 select drops", int'(first), 0);
        while (valid) @(negedge clk);

        // R11: back-to-back frames
        run_frame(1'b0, len, err);
        @(negedge clk); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (valid && idx != 127) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(valid && idx == 0, "R11 no gap restart", int'(idx), 0);
        while (valid) @(negedge clk);

        // R12: resolution change mid-frame
        res = 2'd3;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; len = 0;
        res = 2'd0;
        #1;
        chk($countones(amp_en) == 1024, "R8 live mask", $countones(amp_en), 1024);
        while (valid && len < 2000) begin len++; @(negedge clk); end
        chk(len == 128, "R12 latched length", len, 128);

        // R6: hold mid-frame
        res = 2'd3;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        chk(!valid && !first, "R6 hold clears", valid, 0);
        hold = 1'b0;
        repeat (3) @(negedge clk);
        chk(!valid, "R6 no self start", valid, 0);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(valid && idx == 0, "R6 restart at zero", int'(idx), 0);
        while (valid) @(negedge clk);

        // R7: standby
        hold = 1'b1; start = 1'b1;
        #1;
        chk(!drv_en, "R7 driver off", drv_en, 0);
        chk(amp_en == '0, "R7 amps off", $countones(amp_en), 0);
        @(negedge clk);
        chk(!valid, "R7 token held", valid, 0);
        start = 1'b0;
        #1;
        chk(drv_en, "R7 driver back", drv_en, 1);

        // R9: global pixel reset
        dyn = 1'b0; shut = 1'b1;
        #1;
        chk(pix_rst, "R9 frame reset on", pix_rst, 1);
        shut = 1'b0;
        #1;
        chk(!pix_rst, "R9 shutter low", pix_rst, 0);
        dyn = 1'b1; shut = 1'b1;
        #1;
        chk(!pix_rst, "R9 dynamic mode no reset", pix_rst, 0);
        hold = 1'b0; shut = 1'b0; dyn = 1'b0;
        @(negedge clk);
        chk(!grp_rst, "R10 frame mode strobe low", grp_rst, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule